// File: doc/BRIEF.md
# Compare-Match Periodic Timer Channel

This block is one channel of a 16-bit timer unit. Software programs it over a small register bus that carries byte and halfword accesses. The channel counts ticks of the system clock after a selectable prescaler divides them. Each time the counter equals the compare register it raises a status flag. It can also return the counter to zero, which makes the channel a periodic tick source. The same event drives a level interrupt when that interrupt is enabled.

The channel keeps a copy of the start register that the unit shares across its channels. One bit of that register, chosen by a parameter, runs or halts this channel. Only normal counting and the compare-A path are built. Other mode codes and other clear-source codes are held in their registers and read back, but they never produce counting or clearing.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset every register reads 0, the counter is 0 and `irq` is low.
- R2: Writes land at byte offsets control 0, mode 1, I/O control 2, interrupt enable 4, counter 6 (16-bit), compare A 8 (16-bit) and start 16. Each write reads back unchanged. Unmapped offsets read 0. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: The channel counts only while bit CH_IDX of the start register is 1. The other start bits are held and read back without affecting this channel.
- R4: Control bits [2:0] select the tick rate. Code 0 divides by 1, code 1 by 4, code 2 by 16 and code 3 by 64. Codes 4 to 7 stop counting. The divider phase restarts when the run bit goes from 0 to 1, so with divide-by-N the k-th increment lands kN edges after the start write.
- R5: Mode bits [3:0] other than 0 stop counting.
- R6: When control bits [7:5] equal 1, a tick at which the counter equals compare A loads 0, giving a period of A+1 ticks. With any other code the counter runs on and wraps from 0xFFFF to 0.
- R7: Status bit 0 sets on any tick at which the counter equals compare A.
- R8: Status bit 0 clears only when a status write with bit 0 at 0 follows a status read. Writing 1 has no effect. A write without a preceding read has no effect, and each write consumes the read.
- R9: If the flag sets again between the status read and the clearing write, it stays set.
- R10: `irq` is high exactly while status bit 0 and interrupt-enable bit 0 are both 1.
- R11: A counter write takes priority over counting and over clear-on-match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data; 8-bit registers use bits [7:0] |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Compare-A interrupt, level |

## Verification
On every cycle, the embedded assertions check four things. A stopped or non-normal channel leaves the counter unchanged unless software writes it. A counter write wins over counting. The clear-on-match and wrap paths land on zero. The flag sets after every match and falls only after a status write with bit 0 at 0. Only the bench's scenarios can show the exact counter values reached under each prescaler code, the prescaler phase restart, the read-before-write clear protocol with its re-set race, and the interrupt level following the enable bit.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // register byte offsets inside the channel window
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_MODE = 1;
  localparam int unsigned OFS_IOC  = 2;
  localparam int unsigned OFS_IEN  = 4;
  localparam int unsigned OFS_STAT = 5;
  localparam int unsigned OFS_CNT  = 6;
  localparam int unsigned OFS_CMPA = 8;

  // control field codes
  localparam logic [2:0] CLR_SRC_CMPA = 3'd1;
  localparam logic [3:0] MODE_NORMAL  = 4'h0;
  localparam int unsigned PSC_CODES   = 4;  // internal divider codes 0..3

  typedef struct packed {
    logic [2:0] clr_src;
    logic [1:0] cnt_edge;
    logic [2:0] psc_sel;
  } ctrl_t;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int PS_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       enable,
  input  logic [2:0] sel,
  output logic       tick
);
  import cmp_timer_pkg::*;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;
  logic            sel_ok;

  // divide by 4**sel: tick when the low 2*sel bits are all ones
  always_comb begin
    sel_ok = (int'(sel) < PSC_CODES);
    mask   = '0;
    for (int i = 0; i < PS_W; i++) begin
      if (i < 2 * int'(sel[1:0])) mask[i] = 1'b1;
    end
  end

  assign tick = run && enable && sel_ok && ((ps_q & mask) == mask);

  // held at zero while stopped so the phase restarts on each start
  always_ff @(posedge clk) begin
    if (rst || !run) ps_q <= '0;
    else if (enable && sel_ok) ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             clr_on_match,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match
);
  logic at_cmp;

  assign at_cmp = (cnt_q == cmp_val);
  // a counter write in the same cycle suppresses the event
  assign match  = tick && !wr_en && at_cmp;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_val;
    else if (tick) begin
      if (at_cmp && clr_on_match) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_write_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_q == $past(wr_val));

  assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && clr_on_match && cnt_q == cmp_val) |=> cnt_q == '0);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !clr_on_match && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs #(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 8,
  parameter int START_W   = 8,
  parameter int START_OFS = 16,
  parameter int CH_IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  mode_o,
  output logic [REG_W-1:0]  ien_o,
  output logic [CNT_W-1:0]  cmpa_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              run_o,
  output logic              flag_o
);
  import cmp_timer_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_IOC   = ADDR_W'(OFS_IOC);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CMPA  = ADDR_W'(OFS_CMPA);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(START_OFS);

  logic [REG_W-1:0]   ctrl_q, mode_q, ioc_q, ien_q;
  logic [CNT_W-1:0]   cmpa_q;
  logic [START_W-1:0] start_q;
  logic               flag_q, armed_q;
  logic               stat_wr, stat_rd, clr_req;
  logic [CNT_W-1:0]   rd_mux;

  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign clr_req = stat_wr && !bus_wdata[0] && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      ioc_q   <= '0;
      ien_q   <= '0;
      cmpa_q  <= '0;
      start_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl_q  <= bus_wdata[REG_W-1:0];
        A_MODE:  mode_q  <= bus_wdata[REG_W-1:0];
        A_IOC:   ioc_q   <= bus_wdata[REG_W-1:0];
        A_IEN:   ien_q   <= bus_wdata[REG_W-1:0];
        A_CMPA:  cmpa_q  <= bus_wdata;
        A_START: start_q <= bus_wdata[START_W-1:0];
        default: ;
      endcase
    end
  end

  // compare flag: a new match wins and cancels a pending read
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (match_i) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;

      if (match_i) armed_q <= 1'b0;
      else if (stat_rd) armed_q <= flag_q;
      else if (stat_wr) armed_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:  rd_mux[REG_W-1:0]   = ctrl_q;
      A_MODE:  rd_mux[REG_W-1:0]   = mode_q;
      A_IOC:   rd_mux[REG_W-1:0]   = ioc_q;
      A_IEN:   rd_mux[REG_W-1:0]   = ien_q;
      A_STAT:  rd_mux[0]           = flag_q;
      A_CNT:   rd_mux              = cnt_i;
      A_CMPA:  rd_mux              = cmpa_q;
      A_START: rd_mux[START_W-1:0] = start_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign ctrl_o      = ctrl_q;
  assign mode_o      = mode_q;
  assign ien_o       = ien_q;
  assign cmpa_o      = cmpa_q;
  assign cnt_wr_o    = bus_wr && (bus_addr == A_CNT);
  assign cnt_wdata_o = bus_wdata;
  assign run_o       = start_q[CH_IDX];
  assign flag_o      = flag_q;

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    match_i |=> flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(stat_wr && !bus_wdata[0]));
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 8,
  parameter int START_W   = 8,
  parameter int START_OFS = 16,
  parameter int CH_IDX    = 0,
  parameter int PS_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  import cmp_timer_pkg::*;

  logic [REG_W-1:0] ctrl_raw, mode_raw, ien_raw;
  logic [CNT_W-1:0] cmpa, cnt, cnt_wdata;
  logic             cnt_wr, run, flag, tick, match;
  logic             normal_mode, clr_on_a;
  ctrl_t            ctrl;

  cmp_timer_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W),
    .START_W(START_W), .START_OFS(START_OFS), .CH_IDX(CH_IDX)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt), .match_i(match),
    .ctrl_o(ctrl_raw), .mode_o(mode_raw), .ien_o(ien_raw), .cmpa_o(cmpa),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata),
    .run_o(run), .flag_o(flag)
  );

  assign ctrl        = ctrl_t'(ctrl_raw[7:0]);
  assign normal_mode = (mode_raw[3:0] == MODE_NORMAL);
  assign clr_on_a    = (ctrl.clr_src == CLR_SRC_CMPA);

  cmp_timer_prescale #(.PS_W(PS_W)) u_psc (
    .clk(clk), .rst(rst), .run(run), .enable(normal_mode),
    .sel(ctrl.psc_sel), .tick(tick)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(cnt_wr), .wr_val(cnt_wdata),
    .cmp_val(cmpa), .clr_on_match(clr_on_a),
    .cnt_q(cnt), .match(match)
  );

  assign irq = flag && ien_raw[0];

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!normal_mode && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/cmp_timer_chan_bench.sv
`timescale 1ns/1ps
module cmp_timer_chan_bench;
  localparam logic [4:0] AD_CTRL = 5'd0, AD_MODE = 5'd1, AD_IOC = 5'd2,
                         AD_GAP = 5'd3, AD_IEN = 5'd4, AD_STAT = 5'd5,
                         AD_CNT = 5'd6, AD_CMPA = 5'd8, AD_START = 5'd16;

  typedef struct packed {
    logic [2:0]  sel;
    logic [2:0]  clr;
    logic [3:0]  mode;
    logic [15:0] init;
    logic [15:0] cmpa;
    logic [7:0]  idle;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  // counting spans idle+2 clock edges between the start and stop writes
  localparam vec_t VECS [9] = '{
    '{3'd0, 3'd1, 4'd0, 16'h0000, 16'h0005, 8'd8,   16'h0004, 1'b1},
    '{3'd1, 3'd1, 4'd0, 16'h0000, 16'h0003, 8'd18,  16'h0001, 1'b1},
    '{3'd2, 3'd0, 4'd0, 16'h0000, 16'h0064, 8'd62,  16'h0004, 1'b0},
    '{3'd3, 3'd1, 4'd0, 16'h0000, 16'h0001, 8'd190, 16'h0001, 1'b1},
    '{3'd0, 3'd0, 4'd0, 16'hFFFD, 16'h0002, 8'd5,   16'h0004, 1'b1},
    '{3'd0, 3'd2, 4'd0, 16'h0000, 16'h0003, 8'd8,   16'h000A, 1'b1},
    '{3'd5, 3'd1, 4'd0, 16'h0007, 16'h0003, 8'd6,   16'h0007, 1'b0},
    '{3'd0, 3'd1, 4'd2, 16'h0000, 16'h0003, 8'd6,   16'h0000, 1'b0},
    '{3'd0, 3'd1, 4'd0, 16'h0000, 16'h0000, 8'd3,   16'h0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  cmp_timer_chan u_cmp_timer_chan (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic run_for(input int idle);
    wr(AD_START, 16'h0001);
    repeat (idle) @(negedge clk);
    wr(AD_START, 16'h0000);
  endtask

  initial begin
    logic [15:0] v;
    // R1: reset state
    do_reset();
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rd(AD_CTRL, v);  chk("R1 ctrl", v, 16'h0);
    rd(AD_START, v); chk("R1 start", v, 16'h0);
    rd(AD_STAT, v);  chk("R1 status", v, 16'h0);
    rd(AD_CNT, v);   chk("R1 counter", v, 16'h0);
    rd(AD_CMPA, v);  chk("R1 compare", v, 16'h0);

    // R2: readback at each offset
    wr(AD_CTRL, 16'h005A); rd(AD_CTRL, v); chk("R2 ctrl", v, 16'h005A);
    wr(AD_MODE, 16'h000C); rd(AD_MODE, v); chk("R2 mode", v, 16'h000C);
    wr(AD_IOC, 16'h00A5);  rd(AD_IOC, v);  chk("R2 ioc", v, 16'h00A5);
    wr(AD_IEN, 16'h003C);  rd(AD_IEN, v);  chk("R2 ien", v, 16'h003C);
    wr(AD_CMPA, 16'hBEEF); rd(AD_CMPA, v); chk("R2 compare", v, 16'hBEEF);
    wr(AD_CNT, 16'h1234);  rd(AD_CNT, v);  chk("R2 counter", v, 16'h1234);
    wr(AD_GAP, 16'h00FF);  rd(AD_GAP, v);  chk("R2 unmapped", v, 16'h0000);

    // R4 R5 R6 R7: vector table
    foreach (VECS[i]) begin
      do_reset();
      wr(AD_CNT, VECS[i].init);
      wr(AD_CMPA, VECS[i].cmpa);
      wr(AD_MODE, {12'd0, VECS[i].mode});
      wr(AD_CTRL, {8'd0, VECS[i].clr, 2'b00, VECS[i].sel});
      run_for(int'(VECS[i].idle));
      rd(AD_CNT, v);  chk($sformatf("R4 R5 R6 vec%0d counter", i), v, VECS[i].exp_cnt);
      rd(AD_STAT, v); chk($sformatf("R7 vec%0d flag", i), v, {15'd0, VECS[i].exp_flag});
    end

    // R3: only bit 0 of the start register runs this channel
    do_reset();
    wr(AD_START, 16'h00FE);
    repeat (6) @(negedge clk);
    rd(AD_CNT, v);   chk("R3 other bits no count", v, 16'h0);
    rd(AD_START, v); chk("R3 start readback", v, 16'h00FE);
    run_for(4);
    rd(AD_CNT, v);   chk("R3 own bit counts", v, 16'h0006);

    // R4: divider phase restarts on each start (divide by 4)
    do_reset();
    wr(AD_CMPA, 16'hFFFF);
    wr(AD_CTRL, 16'h0001);
    run_for(1); run_for(1);
    rd(AD_CNT, v); chk("R4 phase restart", v, 16'h0);
    run_for(2);
    rd(AD_CNT, v); chk("R4 first tick after 4", v, 16'h0001);

    // R8 R10: clear protocol and interrupt level
    do_reset();
    wr(AD_IEN, 16'h0001);
    wr(AD_CMPA, 16'h0002);
    wr(AD_CTRL, 16'h0020);
    run_for(3);
    rd(AD_CNT, v); chk("R6 period A+1", v, 16'h0002);
    chk("R10 irq with flag and enable", {15'd0, irq}, 16'h1);
    wr(AD_STAT, 16'h0000);
    chk("R8 write without read", {15'd0, irq}, 16'h1);
    rd(AD_STAT, v); chk("R8 status read", v, 16'h1);
    wr(AD_STAT, 16'h0001);
    chk("R8 write one ignored", {15'd0, irq}, 16'h1);
    wr(AD_STAT, 16'h0000);
    chk("R8 read consumed", {15'd0, irq}, 16'h1);
    rd(AD_STAT, v);
    wr(AD_STAT, 16'h00FE);
    chk("R8 cleared", {15'd0, irq}, 16'h0);
    rd(AD_STAT, v); chk("R8 status zero", v, 16'h0);

    run_for(3);
    wr(AD_IEN, 16'h0000);
    chk("R10 enable off", {15'd0, irq}, 16'h0);
    rd(AD_STAT, v); chk("R10 flag still set", v, 16'h1);

    // R9: re-set between read and write keeps the flag
    rd(AD_STAT, v);
    run_for(5);
    wr(AD_STAT, 16'h0000);
    rd(AD_STAT, v); chk("R9 flag kept", v, 16'h1);

    // R11: counter write wins while running
    do_reset();
    wr(AD_CMPA, 16'h0005);
    wr(AD_CTRL, 16'h0020);
    wr(AD_START, 16'h0001);
    wr(AD_CNT, 16'h0100);
    wr(AD_START, 16'h0000);
    rd(AD_CNT, v); chk("R11 write priority", v, 16'h0102);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule